// File: doc/BRIEF.md
# Flash Program Command Interpreter

This block sits on the device side of a byte-wide parallel flash memory. It watches the chip-enable, write-strobe and output-enable lines together with the address and data buses. It turns host write cycles into array operations. A program operation takes two writes: a setup code, then a write that carries the target location and the byte. The block captures that location and byte internally, so the host buses are free again at once. An internal stop timer then holds the array's program pulse for a fixed time and ends it without help from the host.

A separate command puts the array in verify mode. After a fixed recovery time, reads return the byte stored at the captured location. A third command returns the block to normal reads, where the array follows the external address. The block accepts commands only while the programming-voltage flag is high.

Timer lengths come from the clock frequency parameter. The host strobes are assumed to be synchronous to `clk`.

Top module: `flash_cmd_reg`

## Requirements
- R1: While `rstN` is low, and after it is released, the block is in read mode with `busy`, `progPulse` and `verifyMode` low.
- R2: In read mode, `arrAddr` follows `addr`. `rdData` equals `arrRdData` when `ceN` and `oeN` are both low, and is 00h otherwise.
- R3: A write is taken in the clock cycle where `weN` is first seen high after being low, with `ceN` low. The command byte is the value of `wrData` in that cycle. Holding `weN` low has no effect.
- R4: In read mode, a write of 40h arms programming. The next write captures `addr` and `wrData`, which then drive `arrAddr` and `arrWrData` for the whole pulse, however the buses change. `progPulse` rises one clock after that write is taken.
- R5: `progPulse` stays high for exactly PROG_CYC = (CLK_FREQ_HZ/1000)*PULSE_US/1000 cycles. The block then returns to read mode on its own.
- R6: `busy` is high exactly while the stop timer runs, which covers the program pulse and the verify recovery. Writes taken while `busy` is high are ignored.
- R7: When not busy, a write of C0h enters verify mode. `verifyMode` goes high, `arrAddr` shows the captured address, and `busy` stays high for RECOV_CYC = (CLK_FREQ_HZ/1000)*RECOV_US/1000 cycles. During that time `rdData` reads 00h. After it, `rdData` returns the array byte at the captured address.
- R8: In verify mode, once not busy, a write of 00h returns to read mode. A write of 40h arms programming as in read mode, and a write of C0h restarts verify.
- R9: Any other write code, taken in read mode or in verify mode, leaves the block in read mode.
- R10: While `hvOk` is low, every write is ignored and the block is forced into read mode one clock later. This aborts a running pulse or verify and clears `busy`.
- R11: Write strobes while `ceN` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write strobe, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Host address bus |
| wrData | input | DATA_W | Host write data / command byte |
| hvOk | input | 1 | Programming voltage present |
| arrRdData | input | DATA_W | Byte read from the array at `arrAddr` |
| rdData | output | DATA_W | Read data to host |
| busy | output | 1 | Stop timer running |
| progPulse | output | 1 | Program pulse to the array |
| verifyMode | output | 1 | Array in verify read condition |
| arrAddr | output | ADDR_W | Array address: bus in read mode, captured otherwise |
| arrWrData | output | DATA_W | Captured program byte |

## Verification
The bench builds the block with CLK_FREQ_HZ at 2 MHz. This gives a 20-cycle program pulse and a 12-cycle recovery. Every cycle of both windows can then be counted edge by edge: the full pulse, a pulse shortened by an abort, and a pulse with writes taken during it. The defaults of 10 µs and 6 µs are kept, so the same cycle formula is exercised as at the 125 MHz default.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    ST_READ   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_PROG   = 2'd2,
    ST_VERIFY = 2'd3
  } cmd_state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchOp;     // capture address and data of the program write
    logic useLatched;  // drive the array from the captured address
    logic readOk;      // host reads may see array data
  } dp_ctl_t;

  localparam logic [7:0] CODE_SETUP  = 8'h40;
  localparam logic [7:0] CODE_VERIFY = 8'hC0;
  localparam logic [7:0] CODE_READ   = 8'h00;

  // Microseconds to whole clock cycles, never below one
  function automatic int us_to_cycles(input int clkHz, input int us);
    int c;
    c = ((clkHz / 1000) * us) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/flash_stop_timer.sv
module flash_stop_timer #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [CNT_W-1:0] loadVal,
  output logic             running,
  output logic             lastCyc
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= loadVal;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign running = (cnt != '0);
  assign lastCyc = (cnt == CNT_W'(1));

endmodule

// File: rtl/flash_cmd_ctl.sv
module flash_cmd_ctl
  import flash_cmd_pkg::*;
#(
  parameter int PROG_CYC  = 1250,
  parameter int RECOV_CYC = 750,
  parameter int CNT_W     = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hvOk,
  input  logic             wrEvent,
  input  logic [7:0]       wrCode,
  input  logic             timerRunning,
  input  logic             timerLast,
  output logic             timerLoad,
  output logic [CNT_W-1:0] timerVal,
  output dp_ctl_t          dpCtl,
  output logic             progPulse,
  output logic             verifyMode,
  output logic             busy
);

  localparam logic [CNT_W-1:0] PROG_LD  = CNT_W'(PROG_CYC);
  localparam logic [CNT_W-1:0] RECOV_LD = CNT_W'(RECOV_CYC);

  cmd_state_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_READ;
    else       state <= nextState;
  end

  always_comb begin
    nextState     = state;
    timerLoad     = 1'b0;
    timerVal      = '0;
    dpCtl.latchOp = 1'b0;
    if (!hvOk) begin
      // no programming voltage: fall back to read, stop any timer
      nextState = ST_READ;
      timerLoad = timerRunning;
    end else begin
      unique case (state)
        ST_READ, ST_VERIFY: begin
          if (wrEvent && !timerRunning) begin
            if (wrCode == CODE_SETUP) begin
              nextState = ST_SETUP;
            end else if (wrCode == CODE_VERIFY) begin
              nextState = ST_VERIFY;
              timerLoad = 1'b1;
              timerVal  = RECOV_LD;
            end else begin
              nextState = ST_READ;
            end
          end
        end
        ST_SETUP: begin
          if (wrEvent) begin
            nextState     = ST_PROG;
            dpCtl.latchOp = 1'b1;
            timerLoad     = 1'b1;
            timerVal      = PROG_LD;
          end
        end
        ST_PROG: begin
          if (timerLast) nextState = ST_READ;
        end
        default: nextState = ST_READ;
      endcase
    end
  end

  assign progPulse        = (state == ST_PROG);
  assign verifyMode       = (state == ST_VERIFY);
  assign busy             = timerRunning;
  assign dpCtl.useLatched = (state == ST_PROG) || (state == ST_VERIFY);
  assign dpCtl.readOk     = !timerRunning && (state != ST_PROG);

endmodule

// File: rtl/flash_cmd_dp.sv
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] arrRdData,
  input  dp_ctl_t           dpCtl,
  output logic              wrEvent,
  output logic [7:0]        wrCode,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [DATA_W-1:0] arrWrData,
  output logic [DATA_W-1:0] rdData
);

  logic              weNq;
  logic [ADDR_W-1:0] latAddr;
  logic [DATA_W-1:0] latData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) weNq <= 1'b1;
    else       weNq <= weN;
  end

  // trailing edge of the write strobe while selected
  assign wrEvent = !ceN && !weNq && weN;
  assign wrCode  = wrData[7:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latAddr <= '0;
      latData <= '0;
    end else if (dpCtl.latchOp) begin
      latAddr <= addr;
      latData <= wrData;
    end
  end

  assign arrAddr   = dpCtl.useLatched ? latAddr : addr;
  assign arrWrData = latData;
  assign rdData    = (dpCtl.readOk && !ceN && !oeN) ? arrRdData : '0;

endmodule

// File: rtl/flash_cmd_reg.sv
module flash_cmd_reg
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int CLK_FREQ_HZ = 125_000_000,
  parameter int PULSE_US    = 10,
  parameter int RECOV_US    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              hvOk,
  input  logic [DATA_W-1:0] arrRdData,
  output logic [DATA_W-1:0] rdData,
  output logic              busy,
  output logic              progPulse,
  output logic              verifyMode,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [DATA_W-1:0] arrWrData
);

  localparam int PROG_CYC  = us_to_cycles(CLK_FREQ_HZ, PULSE_US);
  localparam int RECOV_CYC = us_to_cycles(CLK_FREQ_HZ, RECOV_US);
  localparam int MAX_CYC   = (PROG_CYC > RECOV_CYC) ? PROG_CYC : RECOV_CYC;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  dp_ctl_t          dpCtl;
  logic             wrEvent;
  logic [7:0]       wrCode;
  logic             timerLoad;
  logic [CNT_W-1:0] timerVal;
  logic             timerRunning;
  logic             timerLast;

  flash_cmd_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .wrData(wrData), .arrRdData(arrRdData), .dpCtl(dpCtl),
    .wrEvent(wrEvent), .wrCode(wrCode), .arrAddr(arrAddr),
    .arrWrData(arrWrData), .rdData(rdData)
  );

  flash_cmd_ctl #(.PROG_CYC(PROG_CYC), .RECOV_CYC(RECOV_CYC), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rstN(rstN), .hvOk(hvOk), .wrEvent(wrEvent), .wrCode(wrCode),
    .timerRunning(timerRunning), .timerLast(timerLast),
    .timerLoad(timerLoad), .timerVal(timerVal), .dpCtl(dpCtl),
    .progPulse(progPulse), .verifyMode(verifyMode), .busy(busy)
  );

  flash_stop_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rstN(rstN), .load(timerLoad), .loadVal(timerVal),
    .running(timerRunning), .lastCyc(timerLast)
  );

endmodule

// File: rtl/flash_cmd_reg_chk.sv
module flash_cmd_reg_chk #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int PROG_CYC = 1250
) (
  input logic              clk,
  input logic              rstN,
  input logic              hvOk,
  input logic              busy,
  input logic              progPulse,
  input logic              verifyMode,
  input logic [DATA_W-1:0] rdData,
  input logic [ADDR_W-1:0] arrAddr,
  input logic [DATA_W-1:0] arrWrData
);

  int pulseLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          pulseLen <= 0;
    else if (progPulse) pulseLen <= pulseLen + 1;
    else                pulseLen <= 0;
  end

  // R5: a pulse that was not aborted lasts the full stop-timer time
  p_pulse_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(progPulse) && $past(hvOk)) |-> (pulseLen == PROG_CYC));

  // R6: the pulse is always covered by busy
  p_pulse_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    progPulse |-> busy);

  // R6: writes during recovery cannot leave verify mode
  p_verify_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (verifyMode && busy && hvOk) |=> verifyMode);

  // R4: captured address and byte stay put during the pulse
  p_latched_r4: assert property (@(posedge clk) disable iff (!rstN)
    (progPulse && $past(progPulse)) |-> ($stable(arrAddr) && $stable(arrWrData)));

  // R7: program and verify never overlap
  p_exclusive_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(progPulse && verifyMode));

  // R7: host reads are blanked while the timer runs
  p_quiet_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (rdData == '0));

  // R10: without programming voltage the block drops to read mode
  p_hold_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    !hvOk |=> (!progPulse && !verifyMode && !busy));

endmodule

bind flash_cmd_reg flash_cmd_reg_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYC(PROG_CYC)
) u_chk (
  .clk(clk), .rstN(rstN), .hvOk(hvOk), .busy(busy), .progPulse(progPulse),
  .verifyMode(verifyMode), .rdData(rdData), .arrAddr(arrAddr), .arrWrData(arrWrData)
);

// File: tb/flash_cmd_reg_tb.sv
`timescale 1ns/1ps
module flash_cmd_reg_tb;

  localparam int CLK_HZ = 2_000_000;
  localparam int P_CYC  = (2000 * 10) / 1000;  // R5: 20 cycles
  localparam int V_CYC  = (2000 * 6) / 1000;   // R7: 12 cycles

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ceN = 1'b1, weN = 1'b1, oeN = 1'b1, hvOk = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  arrRdData, rdData, arrWrData;
  logic        busy, progPulse, verifyMode;
  logic [15:0] arrAddr;

  always #4 clk = ~clk;

  function automatic logic [7:0] memAt(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign arrRdData = memAt(arrAddr);

  flash_cmd_reg #(.CLK_FREQ_HZ(CLK_HZ)) u_dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN), .addr(addr),
    .wrData(wrData), .hvOk(hvOk), .arrRdData(arrRdData), .rdData(rdData),
    .busy(busy), .progPulse(progPulse), .verifyMode(verifyMode),
    .arrAddr(arrAddr), .arrWrData(arrWrData)
  );

  typedef struct {
    string       req;
    int          sel;
    int unsigned expv;
  } item_t;

  item_t       q[$];
  int          errors = 0;
  int          checks = 0;
  int unsigned measVal = 0;
  bit          done = 0;

  // driver side: queue an expectation
  task automatic expect_(input string req, input int sel, input int unsigned v);
    item_t it;
    it.req = req; it.sel = sel; it.expv = v;
    q.push_back(it);
  endtask

  function automatic int unsigned actual(input int sel);
    case (sel)
      0: return int'(rdData);
      1: return int'(busy);
      2: return int'(progPulse);
      3: return int'(verifyMode);
      4: return int'(arrAddr);
      5: return int'(arrWrData);
      default: return measVal;
    endcase
  endfunction

  // monitor: pops expectations away from the clock edge
  initial begin
    forever begin
      wait (q.size() != 0);
      #2;
      while (q.size() != 0) begin
        item_t it;
        int unsigned a;
        it = q.pop_front();
        a = actual(it.sel);
        checks++;
        if (a !== it.expv) begin
          errors++;
          $display("FAIL %s sel=%0d act=%0h exp=%0h", it.req, it.sel, a, it.expv);
        end
      end
    end
  end

  task automatic doWrite(input logic [15:0] a, input logic [7:0] d);
    ceN = 1'b0; addr = a; wrData = d; weN = 1'b0;
    @(negedge clk);
    weN = 1'b1;
    @(negedge clk);
    ceN = 1'b1;
  endtask

  task automatic countPulse();
    int n = 0;
    while (progPulse && n < 1000) begin n++; @(negedge clk); end
    measVal = n;
  endtask

  task automatic countBusy();
    int n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    measVal = n;
  endtask

  task automatic settle();
    #3;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    expect_("R1 busy in reset", 1, 0);
    expect_("R1 pulse in reset", 2, 0);
    expect_("R1 verify in reset", 3, 0);
    settle();
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    expect_("R1 busy after reset", 1, 0);
    expect_("R1 verify after reset", 3, 0);
    expect_("R1 rdData with oeN high", 0, 0);
    settle();

    // R2 read mode
    @(negedge clk);
    ceN = 0; oeN = 0; addr = 16'h1234;
    expect_("R2 arrAddr follows bus", 4, 16'h1234);
    expect_("R2 read data", 0, memAt(16'h1234));
    settle();
    @(negedge clk); addr = 16'hFFFF;
    expect_("R2 read data top", 0, memAt(16'hFFFF));
    settle();
    @(negedge clk); oeN = 1;
    expect_("R2 oeN high gives 00h", 0, 0);
    settle();
    @(negedge clk); ceN = 1; oeN = 0;
    expect_("R2 ceN high gives 00h", 0, 0);
    settle();
    @(negedge clk); oeN = 1;

    // R11 strobe with chip disabled, then R9 unknown code
    @(negedge clk);
    ceN = 1; wrData = 8'h40; weN = 0;
    @(negedge clk); weN = 1;
    @(negedge clk);
    doWrite(16'h0200, 8'h99);
    expect_("R11 deselected setup ignored", 2, 0);
    expect_("R11 no busy", 1, 0);
    expect_("R9 unknown code stays read", 3, 0);
    settle();

    // R4 and R5 program sequence
    @(negedge clk);
    doWrite(16'h0000, 8'h40);
    expect_("R4 setup alone no pulse", 2, 0);
    settle();
    @(negedge clk);
    doWrite(16'hBEEF, 8'h3C);
    expect_("R4 pulse started", 2, 1);
    expect_("R6 busy with pulse", 1, 1);
    expect_("R4 captured addr", 4, 16'hBEEF);
    expect_("R4 captured data", 5, 8'h3C);
    settle();
    @(negedge clk);
    addr = 16'h0000; wrData = 8'hFF;
    expect_("R4 addr held after bus change", 4, 16'hBEEF);
    expect_("R4 data held after bus change", 5, 8'h3C);
    settle();
    @(negedge clk);
    countPulse();
    expect_("R5 pulse length", 6, P_CYC - 2);
    expect_("R5 back to read, busy low", 1, 0);
    expect_("R5 arrAddr follows bus again", 4, 16'h0000);
    settle();

    // R6 writes during the pulse are ignored
    @(negedge clk);
    doWrite(16'h0000, 8'h40);
    doWrite(16'h0010, 8'hA5);
    doWrite(16'h0000, 8'hC0);
    countPulse();
    expect_("R6 pulse unchanged by write", 6, P_CYC - 2);
    expect_("R6 verify write ignored", 3, 0);
    settle();

    // R7 verify
    @(negedge clk);
    doWrite(16'h3333, 8'hC0);
    ceN = 0; oeN = 0;
    expect_("R7 verify mode", 3, 1);
    expect_("R7 busy in recovery", 1, 1);
    expect_("R7 captured addr in verify", 4, 16'h0010);
    expect_("R7 blank read in recovery", 0, 0);
    settle();
    countBusy();
    expect_("R7 recovery length", 6, V_CYC - 0);
    expect_("R7 verify data", 0, memAt(16'h0010));
    expect_("R7 still verifying", 3, 1);
    settle();
    @(negedge clk); ceN = 1; oeN = 1;

    // R9 unknown code from verify
    @(negedge clk);
    doWrite(16'h0000, 8'h77);
    expect_("R9 unknown in verify to read", 3, 0);
    expect_("R9 arrAddr back to bus", 4, 16'h0000);
    settle();

    // R3 strobe timing: held low does nothing, rising edge samples
    @(negedge clk);
    ceN = 0; weN = 0; wrData = 8'h00;
    @(negedge clk);
    @(negedge clk);
    expect_("R3 held strobe no effect", 3, 0);
    settle();
    wrData = 8'hC0;
    @(negedge clk); weN = 1;
    @(negedge clk); ceN = 1;
    expect_("R3 code sampled at rise", 3, 1);
    settle();
    countBusy();

    // R8 leaving verify
    @(negedge clk);
    doWrite(16'h0000, 8'h00);
    expect_("R8 read code leaves verify", 3, 0);
    settle();
    @(negedge clk);
    doWrite(16'h0000, 8'hC0);
    countBusy();
    doWrite(16'h0000, 8'h40);
    expect_("R8 setup from verify", 3, 0);
    expect_("R8 no pulse yet", 2, 0);
    settle();
    @(negedge clk);
    doWrite(16'h4444, 8'h11);
    expect_("R8 pulse after setup from verify", 2, 1);
    expect_("R8 captured addr", 4, 16'h4444);
    settle();
    countPulse();

    // R10 programming voltage gating
    @(negedge clk);
    hvOk = 0;
    doWrite(16'h0000, 8'h40);
    doWrite(16'h5555, 8'h22);
    expect_("R10 no pulse without voltage", 2, 0);
    expect_("R10 no busy without voltage", 1, 0);
    settle();
    @(negedge clk);
    doWrite(16'h0000, 8'hC0);
    expect_("R10 no verify without voltage", 3, 0);
    settle();
    @(negedge clk);
    hvOk = 1;
    doWrite(16'h0000, 8'h40);
    doWrite(16'h6666, 8'h33);
    expect_("R10 pulse with voltage", 2, 1);
    settle();
    @(negedge clk);
    hvOk = 0;
    @(negedge clk);
    expect_("R10 pulse aborted", 2, 0);
    expect_("R10 busy cleared", 1, 0);
    settle();
    @(negedge clk); hvOk = 1;
    repeat (2) @(negedge clk);

    wait (q.size() == 0);
    #3;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule